// File: doc/BRIEF.md
# Core Power-Island Bring-Up Sequencer

This block is a hardware state machine that takes one secondary processor core out of its powered-down condition. A single-cycle request carries a core index. The sequencer owns one power-control word per core and one shared control word that holds the active-low core reset lines. It steps through a fixed, handshake-gated order. Logic power switches come on first, then the logic power-good indication, then the logic isolation clamp is removed. The memory array is then enabled, its switches and power-good are gated on status, and its clamp is removed. The core reset is released last.

Each status wait is bounded by a programmable cycle limit. If a wait runs out, the run is abandoned and the core stays in reset. If the core is already out of reset, the run ends early and nothing is changed. An index that names no core is refused without sequencing. Only one bring-up runs at a time, and requests that arrive during a run are dropped.

States: `ST_IDLE`, `ST_CHECK`, `ST_LON_SET`, `ST_LON_WAIT`, `ST_LOK_SET`, `ST_LOK_WAIT`, `ST_LCLAMP`, `ST_MPD_CLR`, `ST_MON_SET`, `ST_MON_WAIT`, `ST_MOK_SET`, `ST_MOK_WAIT`, `ST_MCLAMP`, `ST_RST_REL`, `ST_FIN`.

Transitions:
- `ST_IDLE` goes to `ST_CHECK` on a valid request, or to `ST_FIN` on a bad index.
- `ST_CHECK` goes to `ST_FIN` if the core is already running, else to `ST_LON_SET`.
- Each `*_SET` state goes to its `*_WAIT` state.
- Each `*_WAIT` state goes to the next step when its status matches, or to `ST_FIN` when the limit expires.
- `ST_LCLAMP`, `ST_MPD_CLR`, `ST_MCLAMP` and `ST_RST_REL` each advance unconditionally.
- `ST_FIN` returns to `ST_IDLE`.

Top module: `core_pwrup_seq`

## Requirements
- R1: After reset the control word is 0x0000_0000, each per-core power word is 0x0000_8F04 (logic clamp bit 15 set, memory power-down field 11:8 all ones, memory clamp bit 2 set), busy_o and done_o are low.
- R2: A request whose index is not below NCORE (2 or 3 by default) produces done_o with idx_err_o one cycle later, never raises busy_o and changes no register.
- R3: If the control word's reset-release bit at position 13+index is already 1, the run ends with done_o and already_on_o and no register changes.
- R4: The first write sets bits 21:20 (logic power-on request) of the selected power word to 0b11. The sequencer then waits until the core's 2-bit logic power-on status input reads 0b11.
- R5: Next, bits 17:16 (logic power-good request) are set to 0b11 and the sequencer waits for the core's 2-bit power-good status to read 0b11.
- R6: Next, bit 15 is cleared, and then field 11:8 is cleared. Each is a single write with no wait.
- R7: Next, bit 1 (memory on) is set and the sequencer waits for the memory-on status. Then bit 0 (memory good) is set and it waits for the memory-good status. Then bit 2 is cleared.
- R8: Every write is a read-modify-write that keeps all other bits of the word. The other core's power word is never touched, and registers change only while busy_o is high.
- R9: Last, bit 13+index of the control word is set. In the next cycle done_o pulses with no flag, and a completed bring-up leaves the power word at 0x0033_0003.
- R10: busy_o is high from the cycle after an accepted request until the done_o cycle, in which it is low. Requests while busy_o is high are ignored and yield no done_o.
- R11: In each wait, status is sampled on successive cycles 0..tmo_lim_i. A status first seen on cycle tmo_lim_i succeeds. If the status is still absent on that cycle, the run ends with done_o and tmo_err_o, and the control word is unchanged.
- R12: already_on_o, tmo_err_o and idx_err_o are mutually exclusive and are asserted only together with done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Bring-up request pulse |
| core_idx_i | input | IDX_W | Core index of the request |
| tmo_lim_i | input | TO_W | Last sampled cycle of each status wait |
| lgc_on_st_i | input | 2*NCORE | Logic power-on status, 2 bits per core |
| lgc_ok_st_i | input | 2*NCORE | Logic power-good status, 2 bits per core |
| mem_on_st_i | input | NCORE | Memory power-on status per core |
| mem_ok_st_i | input | NCORE | Memory power-good status per core |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse for every accepted or refused request |
| already_on_o | output | 1 | Completion was an early exit (core already running) |
| tmo_err_o | output | 1 | Completion was an aborted wait |
| idx_err_o | output | 1 | Completion was a refused index |
| ctrl_reg_o | output | 32 | Shared control word (reset-release bits 13+index) |
| pwr_reg_o | output | 32*NCORE | Per-core power words, core c at bits 32c+31:32c |

## Verification
Two functions can fall in one cycle. The first is a new request arriving while a run is in progress, and the bench pulses a request for the other core in the middle of a core-0 run. The scoreboard then judges that exactly one completion arrives and that the other core's word is still at its reset value. The second is a status that first appears on the very cycle the wait limit expires. The power-switch model in the bench is given a delay equal to the limit, which must succeed, and a delay one greater, which must abort with the control word unchanged.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

    localparam int REG_W       = 32;
    localparam int RST_BASE    = 13;   // reset-release bit of core c is RST_BASE + c
    localparam int LON_LSB     = 20;   // logic power-on request pair
    localparam int LOK_LSB     = 16;   // logic power-good request pair
    localparam int LCLAMP_BIT  = 15;
    localparam int MPD_LSB     = 8;    // memory power-down field, 4 bits
    localparam int MCLAMP_BIT  = 2;
    localparam int MON_BIT     = 1;
    localparam int MOK_BIT     = 0;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_LON_SET,
        ST_LON_WAIT,
        ST_LOK_SET,
        ST_LOK_WAIT,
        ST_LCLAMP,
        ST_MPD_CLR,
        ST_MON_SET,
        ST_MON_WAIT,
        ST_MOK_SET,
        ST_MOK_WAIT,
        ST_MCLAMP,
        ST_RST_REL,
        ST_FIN
    } pstate_t;

    typedef enum logic [1:0] {
        RES_OK,
        RES_ALREADY,
        RES_TMO,
        RES_BADIDX
    } res_t;

endpackage

// File: rtl/pwrup_timer.sv
module pwrup_timer #(
    parameter int TO_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic [TO_W-1:0] lim_i,
    output logic            expired_o
);
    logic [TO_W-1:0] cnt_q;

    assign expired_o = run_i && (cnt_q == lim_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != lim_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwrup_regs.sv
module pwrup_regs #(
    parameter int          NCORE     = 2,
    parameter int          IDX_W     = 2,
    parameter logic [31:0] PWR_INIT  = 32'h0000_8F04,
    parameter logic [31:0] CTRL_INIT = 32'h0000_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_wr_i,
    input  logic [IDX_W-1:0]    sel_i,
    input  logic [31:0]         set_i,
    input  logic [31:0]         clr_i,
    input  logic                ctrl_wr_i,
    input  logic [31:0]         ctrl_set_i,
    output logic [31:0]         ctrl_o,
    output logic [NCORE*32-1:0] pwr_o
);
    logic [31:0] ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_INIT;
        end else if (ctrl_wr_i) begin
            ctrl_q <= ctrl_q | ctrl_set_i;
        end
    end
    assign ctrl_o = ctrl_q;

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        logic [31:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= PWR_INIT;
            end else if (pwr_wr_i && (sel_i == IDX_W'(c))) begin
                word_q <= (word_q | set_i) & ~clr_i;
            end
        end
        assign pwr_o[c*32 +: 32] = word_q;
    end
endmodule

// File: rtl/core_pwrup_seq.sv
module core_pwrup_seq
    import pwrup_pkg::*;
#(
    parameter int          NCORE     = 2,
    parameter int          IDX_W     = 2,
    parameter int          TO_W      = 8,
    parameter logic [31:0] PWR_INIT  = 32'h0000_8F04,
    parameter logic [31:0] CTRL_INIT = 32'h0000_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [IDX_W-1:0]    core_idx_i,
    input  logic [TO_W-1:0]     tmo_lim_i,
    input  logic [2*NCORE-1:0]  lgc_on_st_i,
    input  logic [2*NCORE-1:0]  lgc_ok_st_i,
    input  logic [NCORE-1:0]    mem_on_st_i,
    input  logic [NCORE-1:0]    mem_ok_st_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                already_on_o,
    output logic                tmo_err_o,
    output logic                idx_err_o,
    output logic [31:0]         ctrl_reg_o,
    output logic [NCORE*32-1:0] pwr_reg_o
);
    localparam logic [IDX_W:0] NCORE_L = (IDX_W+1)'(NCORE);

    pstate_t          state_q, state_d;
    res_t             res_q, res_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    int               sel;

    logic        pwr_wr, ctrl_wr, in_wait, expired;
    logic [31:0] set_m, clr_m, ctrl_set;
    logic        cur_lon, cur_lok, cur_mon, cur_mok, cur_running;

    assign sel         = int'(idx_q);
    assign cur_lon     = (lgc_on_st_i[2*sel +: 2] == 2'b11);
    assign cur_lok     = (lgc_ok_st_i[2*sel +: 2] == 2'b11);
    assign cur_mon     = mem_on_st_i[sel];
    assign cur_mok     = mem_ok_st_i[sel];
    assign cur_running = ctrl_reg_o[RST_BASE + sel];

    pwrup_timer #(.TO_W(TO_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (in_wait),
        .lim_i     (tmo_lim_i),
        .expired_o (expired)
    );

    pwrup_regs #(
        .NCORE(NCORE), .IDX_W(IDX_W), .PWR_INIT(PWR_INIT), .CTRL_INIT(CTRL_INIT)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_wr_i   (pwr_wr),
        .sel_i      (idx_q),
        .set_i      (set_m),
        .clr_i      (clr_m),
        .ctrl_wr_i  (ctrl_wr),
        .ctrl_set_i (ctrl_set),
        .ctrl_o     (ctrl_reg_o),
        .pwr_o      (pwr_reg_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            res_q   <= RES_OK;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            res_q   <= res_d;
            idx_q   <= idx_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        res_d   = res_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if ({1'b0, core_idx_i} >= NCORE_L) begin
                        state_d = ST_FIN;
                        res_d   = RES_BADIDX;
                    end else begin
                        state_d = ST_CHECK;
                        idx_d   = core_idx_i;
                        res_d   = RES_OK;
                    end
                end
            end
            ST_CHECK: begin
                if (cur_running) begin
                    state_d = ST_FIN;
                    res_d   = RES_ALREADY;
                end else begin
                    state_d = ST_LON_SET;
                end
            end
            ST_LON_SET:  state_d = ST_LON_WAIT;
            ST_LON_WAIT: begin
                if (cur_lon)      state_d = ST_LOK_SET;
                else if (expired) begin state_d = ST_FIN; res_d = RES_TMO; end
            end
            ST_LOK_SET:  state_d = ST_LOK_WAIT;
            ST_LOK_WAIT: begin
                if (cur_lok)      state_d = ST_LCLAMP;
                else if (expired) begin state_d = ST_FIN; res_d = RES_TMO; end
            end
            ST_LCLAMP:   state_d = ST_MPD_CLR;
            ST_MPD_CLR:  state_d = ST_MON_SET;
            ST_MON_SET:  state_d = ST_MON_WAIT;
            ST_MON_WAIT: begin
                if (cur_mon)      state_d = ST_MOK_SET;
                else if (expired) begin state_d = ST_FIN; res_d = RES_TMO; end
            end
            ST_MOK_SET:  state_d = ST_MOK_WAIT;
            ST_MOK_WAIT: begin
                if (cur_mok)      state_d = ST_MCLAMP;
                else if (expired) begin state_d = ST_FIN; res_d = RES_TMO; end
            end
            ST_MCLAMP:   state_d = ST_RST_REL;
            ST_RST_REL:  state_d = ST_FIN;
            ST_FIN:      state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o       = 1'b0;
        done_o       = 1'b0;
        already_on_o = 1'b0;
        tmo_err_o    = 1'b0;
        idx_err_o    = 1'b0;
        in_wait      = 1'b0;
        pwr_wr       = 1'b0;
        ctrl_wr      = 1'b0;
        set_m        = '0;
        clr_m        = '0;
        ctrl_set     = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FIN: begin
                done_o       = 1'b1;
                already_on_o = (res_q == RES_ALREADY);
                tmo_err_o    = (res_q == RES_TMO);
                idx_err_o    = (res_q == RES_BADIDX);
            end
            ST_LON_SET: begin
                busy_o = 1'b1; pwr_wr = 1'b1; set_m = 32'h3 << LON_LSB;
            end
            ST_LOK_SET: begin
                busy_o = 1'b1; pwr_wr = 1'b1; set_m = 32'h3 << LOK_LSB;
            end
            ST_LCLAMP: begin
                busy_o = 1'b1; pwr_wr = 1'b1; clr_m = 32'h1 << LCLAMP_BIT;
            end
            ST_MPD_CLR: begin
                busy_o = 1'b1; pwr_wr = 1'b1; clr_m = 32'hF << MPD_LSB;
            end
            ST_MON_SET: begin
                busy_o = 1'b1; pwr_wr = 1'b1; set_m = 32'h1 << MON_BIT;
            end
            ST_MOK_SET: begin
                busy_o = 1'b1; pwr_wr = 1'b1; set_m = 32'h1 << MOK_BIT;
            end
            ST_MCLAMP: begin
                busy_o = 1'b1; pwr_wr = 1'b1; clr_m = 32'h1 << MCLAMP_BIT;
            end
            ST_RST_REL: begin
                busy_o = 1'b1; ctrl_wr = 1'b1; ctrl_set = 32'h1 << (RST_BASE + sel);
            end
            ST_LON_WAIT, ST_LOK_WAIT, ST_MON_WAIT, ST_MOK_WAIT: begin
                busy_o = 1'b1; in_wait = 1'b1;
            end
            default: busy_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/pwrup_chk.sv
module pwrup_chk #(
    parameter int NCORE = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                busy_o,
    input logic                done_o,
    input logic                already_on_o,
    input logic                tmo_err_o,
    input logic                idx_err_o,
    input logic [31:0]         ctrl_reg_o,
    input logic [NCORE*32-1:0] pwr_reg_o
);
    // R12: one flag at most
    a_r12_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({already_on_o, tmo_err_o, idx_err_o}));

    // R12: flags only with completion
    a_r12_flag_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (already_on_o || tmo_err_o || idx_err_o) |-> done_o);

    // R10: completion cycle is not busy
    a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R8: registers change only as a result of a busy cycle
    a_r8_write_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({ctrl_reg_o, pwr_reg_o}) |-> $past(busy_o));

    // R11: an aborted run leaves the reset lines as they were
    a_r11_tmo_keeps_reset: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_err_o |-> $stable(ctrl_reg_o));

    for (genvar c = 0; c < NCORE; c++) begin : g_ord
        // R5: power-good request only after power-on request
        a_r5_lok_after_lon: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr_reg_o[c*32+16 +: 2] != 2'b00) |-> (pwr_reg_o[c*32+20 +: 2] == 2'b11));

        // R7: memory on only after logic clamp and power-down field cleared
        a_r7_mem_after_logic: assert property (@(posedge clk) disable iff (!rst_n)
            pwr_reg_o[c*32+1] |-> (!pwr_reg_o[c*32+15] && pwr_reg_o[c*32+8 +: 4] == 4'h0));

        // R9: reset release only with memory up and clamp removed
        a_r9_release_last: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_reg_o[13+c] |-> (pwr_reg_o[c*32 +: 3] == 3'b011));
    end
endmodule

bind core_pwrup_seq pwrup_chk #(.NCORE(NCORE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .already_on_o (already_on_o),
    .tmo_err_o    (tmo_err_o),
    .idx_err_o    (idx_err_o),
    .ctrl_reg_o   (ctrl_reg_o),
    .pwr_reg_o    (pwr_reg_o)
);

// File: tb/tb_core_pwrup_seq.sv
`timescale 1ns/1ps
module tb_core_pwrup_seq;
    localparam int NCORE = 2;
    localparam logic [31:0] PINIT = 32'h0000_8F04;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  core_idx_i = '0;
    logic [7:0]  tmo_lim_i = 8'd4;
    logic [3:0]  lgc_on_st_i, lgc_ok_st_i;
    logic [1:0]  mem_on_st_i, mem_ok_st_i;
    logic        busy_o, done_o, already_on_o, tmo_err_o, idx_err_o;
    logic [31:0] ctrl_reg_o;
    logic [63:0] pwr_reg_o;

    always #2 clk = ~clk;   // 250 MHz

    core_pwrup_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .core_idx_i(core_idx_i),
        .tmo_lim_i(tmo_lim_i), .lgc_on_st_i(lgc_on_st_i), .lgc_ok_st_i(lgc_ok_st_i),
        .mem_on_st_i(mem_on_st_i), .mem_ok_st_i(mem_ok_st_i), .busy_o(busy_o),
        .done_o(done_o), .already_on_o(already_on_o), .tmo_err_o(tmo_err_o),
        .idx_err_o(idx_err_o), .ctrl_reg_o(ctrl_reg_o), .pwr_reg_o(pwr_reg_o)
    );

    // power-switch model: status follows request after a delay (cycles)
    int d_lon = 0, d_lok = 0, d_mon = 0, d_mok = 0;
    int c_lon[NCORE], c_lok[NCORE], c_mon[NCORE], c_mok[NCORE];

    always @(posedge clk or negedge rst_n) begin
        for (int c = 0; c < NCORE; c++) begin
            if (!rst_n) begin
                c_lon[c] <= 0; c_lok[c] <= 0; c_mon[c] <= 0; c_mok[c] <= 0;
            end else begin
                c_lon[c] <= (pwr_reg_o[c*32+20 +: 2] == 2'b11) ? c_lon[c] + 1 : 0;
                c_lok[c] <= (pwr_reg_o[c*32+16 +: 2] == 2'b11) ? c_lok[c] + 1 : 0;
                c_mon[c] <= pwr_reg_o[c*32+1] ? c_mon[c] + 1 : 0;
                c_mok[c] <= pwr_reg_o[c*32+0] ? c_mok[c] + 1 : 0;
            end
        end
    end

    always_comb begin
        for (int c = 0; c < NCORE; c++) begin
            lgc_on_st_i[2*c +: 2] = ((pwr_reg_o[c*32+20 +: 2] == 2'b11) && c_lon[c] >= d_lon) ? 2'b11 : 2'b00;
            lgc_ok_st_i[2*c +: 2] = ((pwr_reg_o[c*32+16 +: 2] == 2'b11) && c_lok[c] >= d_lok) ? 2'b11 : 2'b00;
            mem_on_st_i[c] = pwr_reg_o[c*32+1] && c_mon[c] >= d_mon;
            mem_ok_st_i[c] = pwr_reg_o[c*32+0] && c_mok[c] >= d_mok;
        end
    end

    // scoreboard
    typedef struct {
        logic [2:0]  flags;   // {already, tmo, idx}
        logic [31:0] ctrl;
        logic [31:0] p0;
        logic [31:0] p1;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0, n_fail = 0, n_done = 0, n_push = 0, cyc = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && done_o) begin
            n_done++;
            if (q.size() == 0) begin
                chk(1'b0, "R10 unexpected completion", 32'(n_done), 32'(n_push));
            end else begin
                exp_t e;
                e = q.pop_front();
                chk({already_on_o, tmo_err_o, idx_err_o} == e.flags, {e.tag, " flags R12"},
                    32'({already_on_o, tmo_err_o, idx_err_o}), 32'(e.flags));
                chk(ctrl_reg_o == e.ctrl, {e.tag, " ctrl"}, ctrl_reg_o, e.ctrl);
                chk(pwr_reg_o[31:0] == e.p0, {e.tag, " pwr0 R8"}, pwr_reg_o[31:0], e.p0);
                chk(pwr_reg_o[63:32] == e.p1, {e.tag, " pwr1 R8"}, pwr_reg_o[63:32], e.p1);
                chk(!busy_o, {e.tag, " busy low at done R10"}, 32'(busy_o), 32'h0);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        d_lon = 0; d_lok = 0; d_mon = 0; d_mok = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic push(input logic [2:0] f, input logic [31:0] c, input logic [31:0] p0,
                        input logic [31:0] p1, input string tag);
        exp_t e;
        e.flags = f; e.ctrl = c; e.p0 = p0; e.p1 = p1; e.tag = tag;
        q.push_back(e);
        n_push++;
    endtask

    task automatic fire(input logic [1:0] idx, input logic [7:0] lim);
        @(negedge clk);
        core_idx_i = idx; tmo_lim_i = lim; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        do_reset();
        // R1 reset state
        chk(ctrl_reg_o == 32'h0, "R1 ctrl reset", ctrl_reg_o, 32'h0);
        chk(pwr_reg_o[31:0] == PINIT, "R1 pwr0 reset", pwr_reg_o[31:0], PINIT);
        chk(pwr_reg_o[63:32] == PINIT, "R1 pwr1 reset", pwr_reg_o[63:32], PINIT);
        chk(!busy_o && !done_o, "R1 busy/done reset", 32'({busy_o, done_o}), 32'h0);

        // R2 bad indices
        push(3'b001, 32'h0, PINIT, PINIT, "R2 idx2");
        fire(2'd2, 8'd4);
        chk(!busy_o, "R2 no busy on bad index", 32'(busy_o), 32'h0);
        drain();
        push(3'b001, 32'h0, PINIT, PINIT, "R2 idx3");
        fire(2'd3, 8'd4);
        drain();

        // R4 R5 R6 R7 R9 full bring-up of core 0; R10 request during run ignored
        push(3'b000, 32'h0000_2000, 32'h0033_0003, PINIT, "R9 core0 bring-up");
        fire(2'd0, 8'd2);
        @(negedge clk);
        chk(busy_o, "R10 busy during run", 32'(busy_o), 32'h1);
        start_i = 1'b1; core_idx_i = 2'd1;
        @(negedge clk);
        start_i = 1'b0;
        drain();
        repeat (20) @(negedge clk);
        chk(pwr_reg_o[63:32] == PINIT, "R10 ignored request left core1", pwr_reg_o[63:32], PINIT);
        chk(n_done == n_push, "R10 no extra completion", 32'(n_done), 32'(n_push));

        // R3 already on
        push(3'b100, 32'h0000_2000, 32'h0033_0003, PINIT, "R3 core0 already on");
        fire(2'd0, 8'd2);
        drain();

        // R11 boundary: status arrives exactly on last sampled cycle
        d_lon = 3; d_lok = 3; d_mon = 3; d_mok = 3;
        push(3'b000, 32'h0000_6000, 32'h0033_0003, 32'h0033_0003, "R11 core1 delay==limit");
        fire(2'd1, 8'd3);
        drain();

        // R11 R4 timeout in logic power-on wait
        do_reset();
        d_lon = 5;
        push(3'b010, 32'h0, PINIT, 32'h0030_8F04, "R11 R4 core1 lon timeout");
        fire(2'd1, 8'd4);
        drain();

        // R11 R5 timeout in power-good wait
        do_reset();
        d_lok = 20;
        push(3'b010, 32'h0, 32'h0033_8F04, PINIT, "R11 R5 core0 lok timeout");
        fire(2'd0, 8'd7);
        drain();

        // R11 R6 R7 timeout in memory-on wait
        do_reset();
        d_mon = 20;
        push(3'b010, 32'h0, 32'h0033_0006, PINIT, "R11 R6 core0 mon timeout");
        fire(2'd0, 8'd7);
        drain();

        // R11 R7 timeout in memory-good wait
        do_reset();
        d_mok = 20;
        push(3'b010, 32'h0, 32'h0033_0007, PINIT, "R11 R7 core0 mok timeout");
        fire(2'd0, 8'd7);
        drain();

        // R11 zero limit with immediate status succeeds
        do_reset();
        push(3'b000, 32'h0000_4000, PINIT, 32'h0033_0003, "R11 limit zero core1");
        fire(2'd1, 8'd0);
        drain();

        chk(n_done == n_push, "R10 completion count", 32'(n_done), 32'(n_push));
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule